// File: doc/BRIEF.md
# Asynchronous Receive Event Detector

This block sits behind a UART receiver core and turns in-band conditions on the receive path into sticky interrupt flags. The upstream core supplies the sampled line level, a one-bit-time tick, and a strobe with each fully assembled character. The block compares every strobed character with a programmable start-transmit (XON) character, stop-transmit (XOFF) character and termination character. Independently of those strobes, it times how long the line stays low, so that it can report a break and, later, the end of that break.

The number of bit times that counts as a break follows the configured frame format: data length, plus one for parity when parity is on, plus one or two stop bits. When in-band flow control is enabled, XON and XOFF matches move a two-state transmitter flow output. Software acknowledges flags by writing ones to an acknowledge vector.

Top module: `rx_event_detect`

## Requirements
- R1: While `rst` is high, all `irq_o` bits go to 0 and `tx_flow_on_o` goes to 1 (transmitter enabled).
- R2: A cycle with `char_valid_i`=1 sets `irq_o[0]` at the next edge when the low N bits of `char_data_i` equal those of `cfg_xon_i`. N = 5 + `cfg_len_i` (`cfg_len_i` 0..3 selects 5..8 data bits), and the upper bits are ignored. This happens whether or not flow control is enabled.
- R3: When `cfg_flow_en_i`=1, an XON match sets `tx_flow_on_o` to 1 and an XOFF match (against `cfg_xoff_i`, same masking) sets it to 0. XON wins when both match. When `cfg_flow_en_i`=0, `tx_flow_on_o` does not change.
- R4: `irq_o[1]` (break) is set when `line_i` has been low for L baud ticks, where L = (5+`cfg_len_i`) + `cfg_par_i` + (`cfg_stop2_i` ? 2 : 1). The flag is set at the edge that takes the L-th tick, and not after L-1 ticks.
- R5: Any cycle with `line_i`=1 restarts the low-time count from zero.
- R6: `irq_o[2]` (break ended) is set only when `line_i` goes high after a break was flagged. A low period shorter than L does not set it.
- R7: A strobed character that matches `cfg_term_i` (same masking as R2) sets `irq_o[3]`.
- R8: Flags are sticky. Writing 1 to `ack_i[k]` clears `irq_o[k]`, but a new event in the same cycle wins and the flag stays 1.
- R9: A break is reported once per low period. Ticks beyond L while the line stays low do not set the flag again after it has been acknowledged.
- R10: Characters presented with `char_valid_i`=0 set no flag and do not change `tx_flow_on_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Sampled receive line level |
| baud_tick_i | input | 1 | One pulse per bit time |
| char_valid_i | input | 1 | Received character strobe |
| char_data_i | input | 8 | Received character |
| cfg_len_i | input | 2 | Data length code, 5 + value bits |
| cfg_par_i | input | 1 | Parity bit present |
| cfg_stop2_i | input | 1 | Two stop bits when 1 |
| cfg_xon_i | input | 8 | Start-transmit character |
| cfg_xoff_i | input | 8 | Stop-transmit character |
| cfg_term_i | input | 8 | Termination character |
| cfg_flow_en_i | input | 1 | In-band flow control enable |
| ack_i | input | 4 | Write-one-to-clear flag acknowledge |
| irq_o | output | 4 | Flags: [0] XON, [1] break, [2] break end, [3] termination |
| tx_flow_on_o | output | 1 | 1 = transmitter enabled, 0 = halted |

## Verification
A low-time counter that is off by one moves the break flag one tick earlier or later. The bench checks the flag on both sides of the limit for two frame formats, so the fault shows within one bit time. A break-active bit left set or cleared wrongly shows up as a missing or spurious break-end flag on the first rising edge of the line. It also shows as a second break report while the line stays low. A wrong flow state or a wrong length mask appears on `tx_flow_on_o` or on the character flags one cycle after the strobe.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;
    localparam int CHAR_W   = 8;
    localparam int MIN_LEN  = 5;
    localparam int MAX_BITS = CHAR_W + 1 + 2;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int NUM_EV   = 4;

    localparam int EV_XON     = 0;
    localparam int EV_BRK     = 1;
    localparam int EV_BRK_END = 2;
    localparam int EV_TERM    = 3;

    typedef enum logic {
        FLOW_HALT = 1'b0,
        FLOW_RUN  = 1'b1
    } flow_t;

    typedef struct packed {
        logic [1:0] len;
        logic       par;
        logic       stop2;
    } fmt_t;

    // bit times of low line that make a break for a given frame format
    function automatic logic [CNT_W-1:0] brk_limit(input fmt_t f);
        logic [CNT_W-1:0] stops;
        stops = f.stop2 ? CNT_W'(2) : CNT_W'(1);
        return CNT_W'(MIN_LEN) + CNT_W'(f.len) + CNT_W'(f.par) + stops;
    endfunction

    // mask keeping only the configured number of data bits
    function automatic logic [CHAR_W-1:0] char_mask(input logic [1:0] len);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < MIN_LEN + int'(len));
        end
        return m;
    endfunction
endpackage

// File: rtl/rx_brk_watch.sv
module rx_brk_watch
    import rx_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             brk_set_o,
    output logic             brk_end_o
);
    logic [CNT_W-1:0] low_cnt;
    logic             in_brk;

    assign brk_set_o = !line_i && tick_i && !in_brk && (low_cnt == limit_i - CNT_W'(1));
    assign brk_end_o = line_i && in_brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            in_brk  <= 1'b0;
        end else if (line_i) begin
            low_cnt <= '0;
            in_brk  <= 1'b0;
        end else if (tick_i && !in_brk) begin
            if (brk_set_o) begin
                low_cnt <= '0;
                in_brk  <= 1'b1;
            end else begin
                low_cnt <= low_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/rx_char_match.sv
module rx_char_match
    import rx_evt_pkg::*;
(
    input  logic              valid_i,
    input  logic [CHAR_W-1:0] data_i,
    input  logic [1:0]        len_i,
    input  logic [CHAR_W-1:0] xon_i,
    input  logic [CHAR_W-1:0] xoff_i,
    input  logic [CHAR_W-1:0] term_i,
    output logic              xon_hit_o,
    output logic              xoff_hit_o,
    output logic              term_hit_o
);
    logic [CHAR_W-1:0] mask;

    always_comb begin
        mask       = char_mask(len_i);
        xon_hit_o  = valid_i && (((data_i ^ xon_i)  & mask) == '0);
        xoff_hit_o = valid_i && (((data_i ^ xoff_i) & mask) == '0);
        term_hit_o = valid_i && (((data_i ^ term_i) & mask) == '0);
    end
endmodule

// File: rtl/rx_flow_fsm.sv
module rx_flow_fsm
    import rx_evt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  logic  xon_hit_i,
    input  logic  xoff_hit_i,
    output flow_t state_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= FLOW_RUN;
        end else if (en_i) begin
            if (xon_hit_i) begin
                state_o <= FLOW_RUN;
            end else if (xoff_hit_i) begin
                state_o <= FLOW_HALT;
            end
        end
    end
endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] flag_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_o[k] <= 1'b0;
            end else if (set_i[k]) begin
                flag_o[k] <= 1'b1;
            end else if (ack_i[k]) begin
                flag_o[k] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_event_detect.sv
module rx_event_detect
    import rx_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              baud_tick_i,
    input  logic              char_valid_i,
    input  logic [CHAR_W-1:0] char_data_i,
    input  logic [1:0]        cfg_len_i,
    input  logic              cfg_par_i,
    input  logic              cfg_stop2_i,
    input  logic [CHAR_W-1:0] cfg_xon_i,
    input  logic [CHAR_W-1:0] cfg_xoff_i,
    input  logic [CHAR_W-1:0] cfg_term_i,
    input  logic              cfg_flow_en_i,
    input  logic [NUM_EV-1:0] ack_i,
    output logic [NUM_EV-1:0] irq_o,
    output logic              tx_flow_on_o
);
    fmt_t             fmt;
    logic [CNT_W-1:0] limit;
    logic             brk_set, brk_end;
    logic             xon_hit, xoff_hit, term_hit;
    logic [NUM_EV-1:0] ev_set;
    flow_t            flow;

    always_comb begin
        fmt.len   = cfg_len_i;
        fmt.par   = cfg_par_i;
        fmt.stop2 = cfg_stop2_i;
        limit     = brk_limit(fmt);
    end

    rx_brk_watch u_brk (
        .clk(clk), .rst(rst), .line_i(line_i), .tick_i(baud_tick_i),
        .limit_i(limit), .brk_set_o(brk_set), .brk_end_o(brk_end)
    );

    rx_char_match u_match (
        .valid_i(char_valid_i), .data_i(char_data_i), .len_i(cfg_len_i),
        .xon_i(cfg_xon_i), .xoff_i(cfg_xoff_i), .term_i(cfg_term_i),
        .xon_hit_o(xon_hit), .xoff_hit_o(xoff_hit), .term_hit_o(term_hit)
    );

    rx_flow_fsm u_flow (
        .clk(clk), .rst(rst), .en_i(cfg_flow_en_i),
        .xon_hit_i(xon_hit), .xoff_hit_i(xoff_hit), .state_o(flow)
    );

    always_comb begin
        ev_set             = '0;
        ev_set[EV_XON]     = xon_hit;
        ev_set[EV_BRK]     = brk_set;
        ev_set[EV_BRK_END] = brk_end;
        ev_set[EV_TERM]    = term_hit;
    end

    rx_flag_bank #(.N(NUM_EV)) u_flags (
        .clk(clk), .rst(rst), .set_i(ev_set), .ack_i(ack_i), .flag_o(irq_o)
    );

    assign tx_flow_on_o = (flow == FLOW_RUN);
endmodule

// File: rtl/rx_event_detect_chk.sv
module rx_event_detect_chk
    import rx_evt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              line_i,
    input logic              baud_tick_i,
    input logic              char_valid_i,
    input logic [CHAR_W-1:0] char_data_i,
    input logic [1:0]        cfg_len_i,
    input logic [CHAR_W-1:0] cfg_xon_i,
    input logic              cfg_flow_en_i,
    input logic [NUM_EV-1:0] ack_i,
    input logic [NUM_EV-1:0] irq_o,
    input logic              tx_flow_on_o
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && tx_flow_on_o));

    a_r2_xon_flag: assert property (@(posedge clk) disable iff (rst)
        (char_valid_i && (((char_data_i ^ cfg_xon_i) & char_mask(cfg_len_i)) == '0))
        |=> irq_o[EV_XON]);

    a_r3_flow_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_flow_en_i |=> $stable(tx_flow_on_o));

    a_r4_brk_on_low_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o[EV_BRK]) |-> ($past(!line_i) && $past(baud_tick_i)));

    a_r6_end_on_high: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o[EV_BRK_END]) |-> $past(line_i));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~ack_i) != '0 |=> ((irq_o & $past(irq_o & ~ack_i)) == $past(irq_o & ~ack_i)));
endmodule

bind rx_event_detect rx_event_detect_chk chk_i (
    .clk(clk), .rst(rst), .line_i(line_i), .baud_tick_i(baud_tick_i),
    .char_valid_i(char_valid_i), .char_data_i(char_data_i), .cfg_len_i(cfg_len_i),
    .cfg_xon_i(cfg_xon_i), .cfg_flow_en_i(cfg_flow_en_i), .ack_i(ack_i),
    .irq_o(irq_o), .tx_flow_on_o(tx_flow_on_o)
);

// File: tb/rx_event_detect_tb_top.sv
`timescale 1ns/1ps
module rx_event_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_i = 1'b1, baud_tick_i = 1'b0, char_valid_i = 1'b0;
    logic [7:0] char_data_i = 8'h00;
    logic [1:0] cfg_len_i = 2'd3;
    logic       cfg_par_i = 1'b0, cfg_stop2_i = 1'b0, cfg_flow_en_i = 1'b0;
    logic [7:0] cfg_xon_i = 8'h11, cfg_xoff_i = 8'h13, cfg_term_i = 8'h0D;
    logic [3:0] ack_i = 4'h0;
    logic [3:0] irq_o;
    logic       tx_flow_on_o;
    int         total = 0, bad = 0;

    always #10 clk = ~clk;

    rx_event_detect dut_i (
        .clk(clk), .rst(rst), .line_i(line_i), .baud_tick_i(baud_tick_i),
        .char_valid_i(char_valid_i), .char_data_i(char_data_i), .cfg_len_i(cfg_len_i),
        .cfg_par_i(cfg_par_i), .cfg_stop2_i(cfg_stop2_i), .cfg_xon_i(cfg_xon_i),
        .cfg_xoff_i(cfg_xoff_i), .cfg_term_i(cfg_term_i), .cfg_flow_en_i(cfg_flow_en_i),
        .ack_i(ack_i), .irq_o(irq_o), .tx_flow_on_o(tx_flow_on_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] d, input logic v);
        @(negedge clk); char_data_i = d; char_valid_i = v;
        @(negedge clk); char_valid_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); baud_tick_i = 1'b1;
            @(negedge clk); baud_tick_i = 1'b0;
        end
    endtask

    task automatic ack(input logic [3:0] m);
        @(negedge clk); ack_i = m;
        @(negedge clk); ack_i = 4'h0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 flags", irq_o, 4'h0);
        chk("R1 flow", tx_flow_on_o, 1'b1);
    endtask

    task automatic t_chars;
        cfg_flow_en_i = 1'b0;
        send_char(8'h13, 1'b1);
        chk("R3 xoff ignored when disabled", tx_flow_on_o, 1'b1);
        send_char(8'h11, 1'b0);
        chk("R10 invalid strobe", irq_o, 4'h0);
        send_char(8'h11, 1'b1);
        chk("R2 xon flag", irq_o, 4'h1);
        ack(4'h1);
        chk("R8 ack clears", irq_o, 4'h0);
        cfg_flow_en_i = 1'b1;
        send_char(8'h13, 1'b0);
        chk("R10 invalid keeps flow", tx_flow_on_o, 1'b1);
        send_char(8'h13, 1'b1);
        chk("R3 xoff halts", tx_flow_on_o, 1'b0);
        send_char(8'h11, 1'b1);
        chk("R3 xon resumes", tx_flow_on_o, 1'b1);
        ack(4'h1);
        cfg_len_i = 2'd0;
        send_char(8'hF1, 1'b1);
        chk("R2 5-bit mask match", irq_o, 4'h1);
        ack(4'h1);
        cfg_len_i = 2'd3;
        send_char(8'hF1, 1'b1);
        chk("R2 8-bit no match", irq_o, 4'h0);
        send_char(8'h0D, 1'b1);
        chk("R7 term flag", irq_o, 4'h8);
        @(negedge clk); char_data_i = 8'h0D; char_valid_i = 1'b1; ack_i = 4'h8;
        @(negedge clk); char_valid_i = 1'b0; ack_i = 4'h0;
        chk("R8 set wins over ack", irq_o, 4'h8);
        ack(4'h8);
        cfg_flow_en_i = 1'b0;
    endtask

    task automatic t_break_8n1;
        @(negedge clk); line_i = 1'b0;
        ticks(8);
        chk("R4 8N1 no break at L-1", irq_o[1], 1'b0);
        ticks(1);
        chk("R4 8N1 break at L=9", irq_o[1], 1'b1);
        ack(4'h2);
        ticks(12);
        chk("R9 break reported once", irq_o[1], 1'b0);
        chk("R6 no end while low", irq_o[2], 1'b0);
        @(negedge clk); line_i = 1'b1;
        @(negedge clk);
        chk("R6 break end flag", irq_o[2], 1'b1);
        ack(4'h4);
    endtask

    task automatic t_restart;
        @(negedge clk); line_i = 1'b0;
        ticks(8);
        @(negedge clk); line_i = 1'b1;
        @(negedge clk); line_i = 1'b0;
        ticks(8);
        chk("R5 restart after high", irq_o[1], 1'b0);
        ticks(1);
        chk("R5 break after full low run", irq_o[1], 1'b1);
        @(negedge clk); line_i = 1'b1;
        @(negedge clk);
        ack(4'h6);
        @(negedge clk); line_i = 1'b0;
        ticks(3);
        @(negedge clk); line_i = 1'b1;
        @(negedge clk);
        chk("R6 short low no end flag", irq_o, 4'h0);
    endtask

    task automatic t_break_7e2;
        cfg_len_i = 2'd2; cfg_par_i = 1'b1; cfg_stop2_i = 1'b1;
        @(negedge clk); line_i = 1'b0;
        ticks(9);
        chk("R4 7E2 no break at L-1", irq_o[1], 1'b0);
        ticks(1);
        chk("R4 7E2 break at L=10", irq_o[1], 1'b1);
        @(negedge clk); line_i = 1'b1;
        @(negedge clk);
        chk("R6 7E2 end flag", irq_o[2], 1'b1);
        cfg_len_i = 2'd3; cfg_par_i = 1'b0; cfg_stop2_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst = 1'b0;
        t_chars();
        t_break_8n1();
        t_restart();
        t_break_7e2();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule